// File: doc/BRIEF.md
# Partitioned Register File with Cross Path

This block holds the architectural registers of a wide-issue datapath that is split into two halves. Each half (side 0 and side 1) owns its own register bank and its own group of functional units. A unit reads two operands per cycle and writes one result per cycle, and all of that traffic stays inside its own bank. This keeps the port count of each bank at half of what a single shared file would need.

A unit can still take an operand from the other half. It does so by setting the remote flag on one of its read ports. There is only one transfer path between the two banks, and it carries one operand per cycle in total. A fixed-priority arbiter picks the requesting read port with the lowest index. Every other unit that asked for a remote operand in that cycle gets a stall and is expected to hold its request.

Reads are combinational and see same-cycle writes. This holds for local reads and for reads over the cross path. Writes take effect at the next rising clock edge.

Top module: `rfx_top`

## Requirements
- R1: A synchronous active-high reset sets every register in both banks to zero, and this also applies after registers have been written.
- R2: Units 0..UNITS_PER_SIDE-1 belong to side 0 and the remaining units belong to side 1. Read port p of unit u has index 2u+p and occupies bits [(2u+p)*AW +: AW] of `rd_addr` and bits [(2u+p)*DATA_W +: DATA_W] of `rd_data`. A port whose remote flag is 0 returns the addressed register of its own side's bank.
- R3: A write from unit u with `wr_en[u]`=1 updates only the addressed register of unit u's own bank. The same register index in the other bank is left unchanged.
- R4: A read port whose remote flag is 1 and which is granted the cross path returns the addressed register of the opposite bank.
- R5: `xgrant` has at most one bit set per cycle. When any remote flag is set, the grant goes to the requesting port with the lowest index.
- R6: For each unit, `stall[u]` is 1 exactly when that unit has a remote request that was not granted. A remote port that is not granted returns zero data.
- R7: A local read of a register that is being written in the same cycle returns the value being written (write-first).
- R8: A cross-path read of a register that is being written in the same cycle on the opposite side returns the value being written.
- R9: If two units on the same side write the same register in one cycle, `wr_conflict[side]` is 1 in that cycle and the write of the lower-indexed unit is the one stored.
- R10: Writes from the two sides to the same register index in the same cycle go to separate banks and do not raise `wr_conflict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 2*NU*AW | Register index for each read port |
| rd_remote | input | 2*NU | Per read port: 1 selects the opposite bank |
| rd_data | output | 2*NU*DATA_W | Operand returned for each read port |
| xgrant | output | 2*NU | One-hot grant of the cross path (or zero) |
| stall | output | NU | Per unit: a remote request is waiting |
| wr_en | input | NU | Per unit write enable |
| wr_addr | input | NU*AW | Per unit write register index |
| wr_data | input | NU*DATA_W | Per unit write data |
| wr_conflict | output | 2 | Per side: same-register double write this cycle |

In the Width column, NU is 2*UNITS_PER_SIDE and AW is the index width, clog2(NUM_REGS).

## Verification
The assertions check two properties of the cross path on every cycle: the grant is one-hot or zero, and it never goes to a port that did not ask for it while some request is waiting. On every cycle they also check that a write from the lowest unit of a side is always the one stored, and that a conflict flag never rises unless at least two writes are present. The bench scenarios are needed for the rest. Only they show which port wins the arbitration and which data each port returns over the cross path. They also show that the write-first bypass works on both local and cross reads, that the two banks stay independent, and that a second reset clears registers that already hold data.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    localparam int RFX_DATA_W         = 32;
    localparam int RFX_NUM_REGS       = 16;
    localparam int RFX_UNITS_PER_SIDE = 4;
    localparam int RFX_RD_PER_UNIT    = 2;
    localparam int RFX_IDX_W          = 8;

    // Result of the cross-path arbitration
    typedef struct packed {
        logic                 valid;
        logic [RFX_IDX_W-1:0] idx;
    } xsel_t;

    // Side that owns a given read port
    function automatic int side_of_port(input int port, input int units_per_side);
        return port / (units_per_side * RFX_RD_PER_UNIT);
    endfunction

    // Position of a read port among its own side's local ports
    function automatic int local_port(input int port, input int units_per_side);
        return port % (units_per_side * RFX_RD_PER_UNIT);
    endfunction

endpackage

// File: rtl/rfx_xarb.sv
module rfx_xarb
    import rfx_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output xsel_t        sel
);

    always_comb begin
        grant     = '0;
        sel.valid = 1'b0;
        sel.idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                sel.valid = 1'b1;
                sel.idx   = RFX_IDX_W'(i);
            end
        end
    end

    // R5
    xgrant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5
    xgrant_served_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> ((grant & req) != '0));

    // R6
    xgrant_only_req_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

endmodule

// File: rtl/rfx_bank.sv
module rfx_bank #(
    parameter int DATA_W = 32,
    parameter int NUM_REGS = 16,
    parameter int NWR = 4,
    parameter int NRD = 9,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NWR-1:0]    wr_en,
    input  logic [NWR*AW-1:0] wr_addr,
    input  logic [NWR*DATA_W-1:0] wr_data,
    input  logic [NRD*AW-1:0] rd_addr,
    output logic [NRD*DATA_W-1:0] rd_data,
    output logic              conflict
);

    logic [DATA_W-1:0] mem [NUM_REGS];
    logic [DATA_W-1:0] nxt [NUM_REGS];

    // Merged next state; lowest unit assigned last so it wins
    always_comb begin
        nxt = mem;
        for (int u = NWR - 1; u >= 0; u--) begin
            if (wr_en[u]) nxt[wr_addr[u*AW +: AW]] = wr_data[u*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_REGS; r++) mem[r] <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) mem[r] <= nxt[r];
        end
    end

    // Write-first reads come from the merged next state
    for (genvar q = 0; q < NRD; q++) begin : g_rd
        assign rd_data[q*DATA_W +: DATA_W] = nxt[rd_addr[q*AW +: AW]];
    end

    always_comb begin
        conflict = 1'b0;
        for (int i = 0; i < NWR; i++) begin
            for (int j = i + 1; j < NWR; j++) begin
                if (wr_en[i] && wr_en[j] &&
                    (wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW]))
                    conflict = 1'b1;
            end
        end
    end

    // R9
    unit0_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en[0] |=> mem[$past(wr_addr[AW-1:0])] == $past(wr_data[DATA_W-1:0]));

    // R9
    conflict_needs_two_chk: assert property (@(posedge clk) disable iff (rst)
        conflict |-> ($countones(wr_en) >= 2));

endmodule

// File: rtl/rfx_top.sv
module rfx_top
    import rfx_pkg::*;
#(
    parameter int DATA_W = RFX_DATA_W,
    parameter int NUM_REGS = RFX_NUM_REGS,
    parameter int UNITS_PER_SIDE = RFX_UNITS_PER_SIDE,
    localparam int AW = $clog2(NUM_REGS),
    localparam int NU = 2 * UNITS_PER_SIDE,
    localparam int NP = NU * RFX_RD_PER_UNIT,
    localparam int LP = UNITS_PER_SIDE * RFX_RD_PER_UNIT,
    localparam int BRD = LP + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP*AW-1:0]     rd_addr,
    input  logic [NP-1:0]        rd_remote,
    output logic [NP*DATA_W-1:0] rd_data,
    output logic [NP-1:0]        xgrant,
    output logic [NU-1:0]        stall,
    input  logic [NU-1:0]        wr_en,
    input  logic [NU*AW-1:0]     wr_addr,
    input  logic [NU*DATA_W-1:0] wr_data,
    output logic [1:0]           wr_conflict
);

    xsel_t             xsel;
    logic [AW-1:0]     xaddr;
    logic [BRD*DATA_W-1:0] bank_rd [2];

    rfx_xarb #(.N(NP)) i_xarb (
        .clk   (clk),
        .rst   (rst),
        .req   (rd_remote),
        .grant (xgrant),
        .sel   (xsel)
    );

    assign xaddr = rd_addr[int'(xsel.idx)*AW +: AW];

    // Each bank serves its local ports plus one cross port at the top
    for (genvar s = 0; s < 2; s++) begin : g_side
        rfx_bank #(
            .DATA_W   (DATA_W),
            .NUM_REGS (NUM_REGS),
            .NWR      (UNITS_PER_SIDE),
            .NRD      (BRD)
        ) i_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en[s*UNITS_PER_SIDE +: UNITS_PER_SIDE]),
            .wr_addr  (wr_addr[s*UNITS_PER_SIDE*AW +: UNITS_PER_SIDE*AW]),
            .wr_data  (wr_data[s*UNITS_PER_SIDE*DATA_W +: UNITS_PER_SIDE*DATA_W]),
            .rd_addr  ({xaddr, rd_addr[s*LP*AW +: LP*AW]}),
            .rd_data  (bank_rd[s]),
            .conflict (wr_conflict[s])
        );
    end

    // Route each read port to its local bank or the cross port of the far bank
    for (genvar p = 0; p < NP; p++) begin : g_port
        localparam int SP = side_of_port(p, UNITS_PER_SIDE);
        localparam int LQ = local_port(p, UNITS_PER_SIDE);
        always_comb begin
            if (!rd_remote[p])
                rd_data[p*DATA_W +: DATA_W] = bank_rd[SP][LQ*DATA_W +: DATA_W];
            else if (xgrant[p])
                rd_data[p*DATA_W +: DATA_W] = bank_rd[1-SP][LP*DATA_W +: DATA_W];
            else
                rd_data[p*DATA_W +: DATA_W] = '0;
        end
    end

    for (genvar u = 0; u < NU; u++) begin : g_stall
        assign stall[u] = |(rd_remote[u*RFX_RD_PER_UNIT +: RFX_RD_PER_UNIT]
                            & ~xgrant[u*RFX_RD_PER_UNIT +: RFX_RD_PER_UNIT]);
    end

    // R6
    stall_has_waiter_chk: assert property (@(posedge clk) disable iff (rst)
        (|stall) |-> ($countones(rd_remote) >= 2));

endmodule

// File: tb/test_rfx_top.sv
module test_rfx_top;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NU = 8;
    localparam int NP = 16;
    localparam int NV = 6;

    // {unit[2:0], reg[3:0], data[31:0]}
    localparam logic [38:0] VEC [NV] = '{
        {3'd0, 4'd1,  32'h1111_1111},
        {3'd5, 4'd1,  32'h2222_2222},
        {3'd3, 4'd15, 32'h3333_4444},
        {3'd7, 4'd0,  32'hA5A5_A5A5},
        {3'd2, 4'd8,  32'h0F0F_0F0F},
        {3'd4, 4'd15, 32'hDEAD_BEEF}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP*AW-1:0]  rd_addr = '0;
    logic [NP-1:0]     rd_remote = '0;
    logic [NP*DW-1:0]  rd_data;
    logic [NP-1:0]     xgrant;
    logic [NU-1:0]     stall;
    logic [NU-1:0]     wr_en = '0;
    logic [NU*AW-1:0]  wr_addr = '0;
    logic [NU*DW-1:0]  wr_data = '0;
    logic [1:0]        wr_conflict;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [2][16];

    rfx_top i_rfx_top (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_remote(rd_remote),
        .rd_data(rd_data), .xgrant(xgrant), .stall(stall), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_conflict(wr_conflict)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_rd(input int u, input int p, input logic [3:0] a, input logic rem);
        rd_addr[(u*2+p)*AW +: AW] = a;
        rd_remote[u*2+p] = rem;
    endtask

    function automatic logic [31:0] get_rd(input int u, input int p);
        return rd_data[(u*2+p)*DW +: DW];
    endfunction

    task automatic set_wr(input int u, input logic [3:0] a, input logic [31:0] d);
        wr_en[u] = 1'b1;
        wr_addr[u*AW +: AW] = a;
        wr_data[u*DW +: DW] = d;
    endtask

    task automatic clear_in();
        rd_addr = '0; rd_remote = '0; wr_en = '0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic commit();
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog (R1..): got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < 16; r++) model[s][r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: all registers zero after reset
        for (int r = 0; r < 16; r++) begin
            set_rd(0, 0, 4'(r), 1'b0);
            set_rd(4, 0, 4'(r), 1'b0);
            #1;
            chk("R1 side0 reset", get_rd(0, 0), 32'h0);
            chk("R1 side1 reset", get_rd(4, 0), 32'h0);
        end
        chk("R6 no stall idle", 32'(stall), 32'h0);
        chk("R9 no conflict idle", 32'(wr_conflict), 32'h0);
        clear_in();

        // R2 R3 R4: vector table
        for (int v = 0; v < NV; v++) begin
            int u, sd, rr;
            logic [31:0] d;
            u = int'(VEC[v][38:36]);
            rr = int'(VEC[v][35:32]);
            d = VEC[v][31:0];
            sd = u / 4;
            @(negedge clk);
            set_wr(u, 4'(rr), d);
            commit();
            model[sd][rr] = d;
            set_rd(u ^ 1, 1, 4'(rr), 1'b0);
            set_rd(u ^ 4, 0, 4'(rr), 1'b1);
            set_rd(u ^ 4, 1, 4'(rr), 1'b0);
            #1;
            chk("R2 local read", get_rd(u ^ 1, 1), model[sd][rr]);
            chk("R4 cross read", get_rd(u ^ 4, 0), model[sd][rr]);
            chk("R5 cross grant", 32'(xgrant), 32'(16'(1) << ((u ^ 4) * 2)));
            chk("R3 other bank untouched", get_rd(u ^ 4, 1), model[1-sd][rr]);
            clear_in();
        end

        // R5 R6: arbitration among ports 3, 4 and 10
        @(negedge clk);
        set_rd(1, 1, 4'd15, 1'b1);
        set_rd(5, 0, 4'd0, 1'b1);
        set_rd(2, 0, 4'd15, 1'b1);
        #1;
        chk("R5 lowest port wins", 32'(xgrant), 32'h0000_0008);
        chk("R6 losers stalled", 32'(stall), 32'h0000_0024);
        chk("R6 loser data zero", get_rd(5, 0), 32'h0);
        chk("R4 winner data", get_rd(1, 1), model[1][15]);
        set_rd(1, 1, 4'd0, 1'b0);
        #1;
        chk("R5 next winner", 32'(xgrant), 32'h0000_0010);
        chk("R6 remaining stall", 32'(stall), 32'h0000_0020);
        chk("R4 next winner data", get_rd(2, 0), model[1][15]);
        clear_in();

        // R7: local write-first bypass
        @(negedge clk);
        set_wr(2, 4'd7, 32'h7777_0000);
        set_rd(3, 0, 4'd7, 1'b0);
        #1;
        chk("R7 local bypass", get_rd(3, 0), 32'h7777_0000);
        commit();
        model[0][7] = 32'h7777_0000;

        // R8: cross-path write-first bypass
        set_wr(6, 4'd9, 32'h9999_8888);
        set_rd(0, 0, 4'd9, 1'b1);
        #1;
        chk("R8 cross bypass", get_rd(0, 0), 32'h9999_8888);
        commit();
        model[1][9] = 32'h9999_8888;

        // R9: same-side double write
        set_wr(1, 4'd5, 32'hAAAA_0001);
        set_wr(3, 4'd5, 32'hBBBB_0003);
        #1;
        chk("R9 conflict flag", 32'(wr_conflict), 32'h1);
        commit();
        model[0][5] = 32'hAAAA_0001;
        set_rd(0, 0, 4'd5, 1'b0);
        #1;
        chk("R9 lower unit kept", get_rd(0, 0), 32'hAAAA_0001);
        clear_in();

        // R10: both sides write the same index
        @(negedge clk);
        set_wr(0, 4'd6, 32'h6060_6060);
        set_wr(4, 4'd6, 32'h0606_0606);
        #1;
        chk("R10 no cross-side conflict", 32'(wr_conflict), 32'h0);
        commit();
        set_rd(1, 0, 4'd6, 1'b0);
        set_rd(5, 0, 4'd6, 1'b0);
        #1;
        chk("R10 side0 value", get_rd(1, 0), 32'h6060_6060);
        chk("R10 side1 value", get_rd(5, 0), 32'h0606_0606);
        clear_in();

        // R1: reset again after data is present
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        set_rd(0, 0, 4'd1, 1'b0);
        set_rd(4, 0, 4'd15, 1'b0);
        #1;
        chk("R1 reset clears side0", get_rd(0, 0), 32'h0);
        chk("R1 reset clears side1", get_rd(4, 0), 32'h0);
        clear_in();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule